// File: doc/BRIEF.md
# RTS/CTS Hardware Flow Controller

This block carries out out-of-band handshaking for a serial port. It does not shift any character bits. On the receive side it drives the request-to-send line `rtsOut`, which tells the remote end to hold off. Two conditions make it do so: the local receiver is switched off, or a DMA engine has reported that its receive buffer is full. The buffer-full state is a flag that the DMA sets with one strobe. Another strobe clears it once a fresh buffer has been allocated.

On the transmit side the block watches the clear-to-send input `ctsIn`, which it synchronises first. It hands the character serializer a one-cycle permission to start the next character. While synchronised CTS is high, no new character may start. A character that is already on the line (`txBusy`) is left to finish. Every level change of the synchronised CTS sets a sticky change bit, and that bit can raise an interrupt.

All the gating applies only when the mode field holds the handshaking code. In any other mode, RTS stays low and CTS does not affect transmission. The change bit still records CTS edges in every mode.

Top module: `rts_cts_flow`

## Requirements
- R1: Handshaking is active only when `modeSel` equals 4'h2. With any other code, `rtsOut` is 0 whatever the receiver and buffer state, and `txGrant` ignores CTS.
- R2: In handshaking mode, `rtsOut` is 1 in the same cycle that `rxEnable` is 0.
- R3: A `bufFullSet` pulse sets the buffer-full flag at the next clock edge, and from then on `rtsOut` is 1 in handshaking mode. When set and clear arrive in the same cycle, the set wins.
- R4: A `bufFullClr` pulse without a set clears the flag at the next edge. `rtsOut` then returns to 0 if the receiver is enabled.
- R5: `txGrant` is 1 only in a cycle where `txReq` and `bitTick` are both 1 and `txBusy` is 0. In handshaking mode it is also 0 while synchronised CTS is 1.
- R6: Any level change of synchronised CTS, rising or falling, sets `ctsChange` three clock edges after the edge on `ctsIn`. The flag stays set until it is cleared. `ctsIrq` equals `ctsChange` AND `ctsIrqEn`.
- R7: A `staReset` pulse clears `ctsChange` at the next edge. If a new CTS change is detected in that same cycle, the flag stays 1.
- R8: `ctsIn` passes through two flip-flops. A rising `ctsIn` has no effect on `txGrant` after one clock edge and blocks it after the second.
- R9: After synchronised CTS goes low, `txGrant` is given on the first cycle with `bitTick` high while `txReq` is pending.
- R10: After reset, `ctsChange`, `ctsIrq` and the buffer-full flag are 0, so `rtsOut` is 0 with the receiver enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 4 | Port mode field; 4'h2 selects handshaking |
| rxEnable | input | 1 | Receiver enabled |
| bufFullSet | input | 1 | DMA strobe: receive buffer full |
| bufFullClr | input | 1 | Strobe: new receive buffer allocated |
| ctsIn | input | 1 | Clear-to-send from the remote side (asynchronous, high = stop) |
| rtsOut | output | 1 | Request-to-send to the remote side (high = stop) |
| txReq | input | 1 | Serializer has a queued character |
| bitTick | input | 1 | Bit-clock boundary strobe |
| txBusy | input | 1 | A character is currently being shifted out |
| txGrant | output | 1 | Permission to start the queued character this cycle |
| staReset | input | 1 | Status reset strobe; clears the change flag |
| ctsIrqEn | input | 1 | Interrupt enable for CTS change |
| ctsChange | output | 1 | Sticky CTS level-change flag |
| ctsIrq | output | 1 | CTS change interrupt request |

## Verification
Two collisions matter. The first is a detected CTS edge in the same cycle as a status-reset strobe. The bench provokes it by raising `ctsIn` and asserting `staReset` exactly in the cycle after the second synchroniser edge. The flag must read 1 afterwards, and a later lone strobe must clear it. The second is a buffer-full set and a buffer-full clear arriving together. The bench expects `rtsOut` to stay high and judges it one edge later.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef struct packed {
    logic chgSet;   // record a CTS level change
    logic chgClr;   // drop the sticky change flag
    logic fullSet;  // DMA reports receive buffer full
    logic fullClr;  // fresh receive buffer allocated
  } flowStrobe_t;
endpackage

// File: rtl/flow_datapath.sv
module flow_datapath
  import flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctsIn,
  input  flowStrobe_t strb,
  output logic        ctsSync,
  output logic        ctsEdge,
  output logic        bufFull,
  output logic        chgFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          ctsPrev;

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[LAST-1:0], ctsIn};
  end

  assign ctsSync = syncQ[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctsPrev <= 1'b0;
    else       ctsPrev <= ctsSync;
  end

  assign ctsEdge = ctsSync ^ ctsPrev;

  // set has priority over clear for both flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bufFull <= 1'b0;
    else if (strb.fullSet) bufFull <= 1'b1;
    else if (strb.fullClr) bufFull <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            chgFlag <= 1'b0;
    else if (strb.chgSet) chgFlag <= 1'b1;
    else if (strb.chgClr) chgFlag <= 1'b0;
  end

  p_full_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fullSet |=> bufFull);
  p_full_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fullClr && !strb.fullSet) |=> !bufFull);
  p_chg_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.chgSet |=> chgFlag);
  p_chg_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlag && !strb.chgClr) |=> chgFlag);
endmodule

// File: rtl/flow_control.sv
module flow_control
  import flow_pkg::*;
#(
  parameter int               MODE_W  = 4,
  parameter logic [MODE_W-1:0] HS_CODE = 4'h2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              rxEnable,
  input  logic              bufFullSet,
  input  logic              bufFullClr,
  input  logic              staReset,
  input  logic              txReq,
  input  logic              bitTick,
  input  logic              txBusy,
  input  logic              ctsIrqEn,
  input  logic              ctsSync,
  input  logic              ctsEdge,
  input  logic              bufFull,
  input  logic              chgFlag,
  output flowStrobe_t       strb,
  output logic              rtsOut,
  output logic              txGrant,
  output logic              ctsIrq
);
  logic hsMode;
  logic ctsHold;

  assign hsMode  = (modeSel == HS_CODE);
  assign ctsHold = hsMode & ctsSync;

  always_comb begin
    strb         = '0;
    strb.chgSet  = ctsEdge;
    strb.chgClr  = staReset;
    strb.fullSet = bufFullSet;
    strb.fullClr = bufFullClr;
  end

  assign rtsOut  = hsMode & (~rxEnable | bufFull);
  assign txGrant = txReq & bitTick & ~txBusy & ~ctsHold;
  assign ctsIrq  = chgFlag & ctsIrqEn;

  p_mode_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !hsMode |-> !rtsOut);
  p_cts_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hsMode && ctsSync) |-> !txGrant);
  p_busy_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !txGrant);
endmodule

// File: rtl/rts_cts_flow.sv
module rts_cts_flow
  import flow_pkg::*;
#(
  parameter int               MODE_W      = 4,
  parameter logic [MODE_W-1:0] HS_CODE     = 4'h2,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              rxEnable,
  input  logic              bufFullSet,
  input  logic              bufFullClr,
  input  logic              ctsIn,
  output logic              rtsOut,
  input  logic              txReq,
  input  logic              bitTick,
  input  logic              txBusy,
  output logic              txGrant,
  input  logic              staReset,
  input  logic              ctsIrqEn,
  output logic              ctsChange,
  output logic              ctsIrq
);
  flowStrobe_t strb;
  logic ctsSync, ctsEdge, bufFull, chgFlag;

  flow_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .ctsIn(ctsIn), .strb(strb),
    .ctsSync(ctsSync), .ctsEdge(ctsEdge), .bufFull(bufFull), .chgFlag(chgFlag)
  );

  flow_control #(.MODE_W(MODE_W), .HS_CODE(HS_CODE)) i_ctl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .rxEnable(rxEnable),
    .bufFullSet(bufFullSet), .bufFullClr(bufFullClr), .staReset(staReset),
    .txReq(txReq), .bitTick(bitTick), .txBusy(txBusy), .ctsIrqEn(ctsIrqEn),
    .ctsSync(ctsSync), .ctsEdge(ctsEdge), .bufFull(bufFull), .chgFlag(chgFlag),
    .strb(strb), .rtsOut(rtsOut), .txGrant(txGrant), .ctsIrq(ctsIrq)
  );

  assign ctsChange = chgFlag;
endmodule

// File: tb/test_rts_cts_flow.sv
module test_rts_cts_flow;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] modeSel = 4'h2;
  logic rxEnable = 1'b1, bufFullSet = 1'b0, bufFullClr = 1'b0, ctsIn = 1'b0;
  logic txReq = 1'b0, bitTick = 1'b0, txBusy = 1'b0, staReset = 1'b0, ctsIrqEn = 1'b0;
  logic rtsOut, txGrant, ctsChange, ctsIrq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rts_cts_flow i_rts_cts_flow (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .rxEnable(rxEnable),
    .bufFullSet(bufFullSet), .bufFullClr(bufFullClr), .ctsIn(ctsIn),
    .rtsOut(rtsOut), .txReq(txReq), .bitTick(bitTick), .txBusy(txBusy),
    .txGrant(txGrant), .staReset(staReset), .ctsIrqEn(ctsIrqEn),
    .ctsChange(ctsChange), .ctsIrq(ctsIrq)
  );

  // [10:7] mode [6] rxEnable [5] cts [4] txReq [3] bitTick [2] txBusy [1] expRts [0] expGrant
  localparam int NVEC = 11;
  localparam logic [10:0] VECS [NVEC] = '{
    11'b0010_1_0_1_1_0_0_1,  // R5 free to send
    11'b0010_0_0_1_1_0_1_1,  // R2 receiver off
    11'b0010_1_1_1_1_0_0_0,  // R5 cts stops start
    11'b0010_1_1_1_1_1_0_0,  // R5 cts and busy
    11'b0010_1_0_1_1_1_0_0,  // R5 busy
    11'b0010_1_0_1_0_0_0_0,  // R5 no bit tick
    11'b0010_1_0_0_1_0_0_0,  // R5 nothing queued
    11'b0000_0_1_1_1_0_0_1,  // R1 mode 0
    11'b0111_1_1_1_1_0_0_1,  // R1 mode 7
    11'b0011_0_0_1_1_0_0_1,  // R1 mode 3
    11'b0010_0_1_1_1_0_1_0   // R2 R5 both
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    check("R10 rts", rtsOut, 1'b0);
    check("R10 change", ctsChange, 1'b0);
    check("R10 irq", ctsIrq, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      {modeSel, rxEnable, ctsIn, txReq, bitTick, txBusy} = VECS[i][10:2];
      step(3);
      check($sformatf("vec%0d R1 R2 rts", i), rtsOut, VECS[i][1]);
      check($sformatf("vec%0d R1 R5 grant", i), txGrant, VECS[i][0]);
    end

    // settle: mode 2, cts low, clear flag
    modeSel = 4'h2; rxEnable = 1'b1; ctsIn = 1'b0; txReq = 1'b1; bitTick = 1'b1; txBusy = 1'b0;
    step(3);
    staReset = 1'b1; step(1); staReset = 1'b0;
    check("R7 clear", ctsChange, 1'b0);

    // R3 / R4 buffer full
    bufFullSet = 1'b1; step(1); bufFullSet = 1'b0;
    check("R3 set rts", rtsOut, 1'b1);
    bufFullSet = 1'b1; bufFullClr = 1'b1; step(1);
    bufFullSet = 1'b0; bufFullClr = 1'b0;
    check("R3 set wins", rtsOut, 1'b1);
    modeSel = 4'h0; step(1);
    check("R1 full ignored", rtsOut, 1'b0);
    modeSel = 4'h2; step(1);
    check("R3 full held", rtsOut, 1'b1);
    bufFullClr = 1'b1; step(1); bufFullClr = 1'b0;
    check("R4 clear rts", rtsOut, 1'b0);

    // R8 / R6 rising cts
    ctsIrqEn = 1'b1;
    ctsIn = 1'b1; step(1);
    check("R8 one edge grant", txGrant, 1'b1);
    step(1);
    check("R8 two edges grant", txGrant, 1'b0);
    check("R6 not yet", ctsChange, 1'b0);
    step(1);
    check("R6 rise sets", ctsChange, 1'b1);
    check("R6 irq", ctsIrq, 1'b1);
    ctsIrqEn = 1'b0; #1;
    check("R6 irq masked", ctsIrq, 1'b0);
    staReset = 1'b1; step(1); staReset = 1'b0;
    check("R7 clears", ctsChange, 1'b0);

    // R9 falling cts: resume on first bit tick
    bitTick = 1'b0;
    ctsIn = 1'b0; step(2);
    check("R9 waits tick", txGrant, 1'b0);
    bitTick = 1'b1; #1;
    check("R9 resume", txGrant, 1'b1);
    step(1);
    check("R6 fall sets", ctsChange, 1'b1);
    staReset = 1'b1; step(1); staReset = 1'b0;

    // R7 collision: clear strobe in the detect cycle
    ctsIn = 1'b1; step(2);
    staReset = 1'b1; step(1); staReset = 1'b0;
    check("R7 set wins", ctsChange, 1'b1);
    staReset = 1'b1; step(1); staReset = 1'b0;
    check("R7 later clear", ctsChange, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule